// File: doc/BRIEF.md
# Four-Voice Sampled Audio Playback Unit

This block plays four independent streams of 8-bit signed PCM held in word-wide memory. Each voice owns a start pointer, a block length in words, a period and a volume. Once enabled, a voice asks a memory arbiter for one 16-bit word at a time and splits it into two samples, the upper byte first. It holds each sample for a programmable number of clock ticks and scales it linearly by its volume. At the end of a block it wraps back to its start registers without a break.

Every wrap pulses a per-voice interrupt. Software uses that pulse to rewrite the start registers for the block that follows. Even-numbered voices add into the right output and odd-numbered voices into the left.

Any voice can instead act as a modulator for the next voice in a ring (0 to 1, 1 to 2, 2 to 3, 3 to 0). Each fetched word is then written into the neighbour's volume, period, or both in turn, and the modulator itself stays silent.

Top module: `audio_voice_mixer`

## Requirements
- R1: After reset, both outputs are zero and no fetch request or interrupt is active.
- R2: A voice plays words from consecutive addresses beginning at its start pointer. Each word gives two signed samples, bits 15:8 first and then bits 7:0. `fetchAddr` holds steady while a request waits for its acknowledge.
- R3: Each sample stays on the output for exactly `period` clock cycles. With the fetch acknowledged at once, the first sample appears three edges after `dmaEn` rises.
- R4: A period written below 124 behaves as 124.
- R5: A voice's contribution is its sample times its volume, a 15-bit signed product. 0 mutes the voice, and any volume above 64 acts as 64.
- R6: After `length` words the pointer and word count reload from the start registers and playback continues. Each reload raises `irq` for that voice for one cycle.
- R7: Voices 0 and 2 add into `outRight`, and voices 1 and 3 add into `outLeft`.
- R8: With `modVol[c]` set, voice c sends each fetched word to the volume of voice (c+1) mod 4 at its sample pace, and voice c contributes zero to the mix.
- R9: With `modPer[c]` set, voice c sends each fetched word to the period of voice (c+1) mod 4 in the same way.
- R10: With both bits set, the words alternate between the two targets, volume first after each start.
- R11: A voice requests a word only when its holding word is fully used up. After an acknowledged fetch, no request follows in the next cycle. A pending request stays up until it is acknowledged.
- R12: When `dmaEn` falls, the request drops in the same cycle and no further word is taken. The current sample is kept to the end of its period, after which the voice goes idle and outputs zero.

Register select encoding (`regSel`): 0 start pointer, 1 length, 2 period, 3 volume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regChan | input | 2 | Voice addressed by the write |
| regSel | input | 2 | Register addressed: 0 pointer, 1 length, 2 period, 3 volume |
| regData | input | 16 | Write data |
| dmaEn | input | 4 | Per-voice playback enable |
| modVol | input | 4 | Voice c drives the volume of voice (c+1) mod 4 |
| modPer | input | 4 | Voice c drives the period of voice (c+1) mod 4 |
| fetchReq | output | 4 | Per-voice word request |
| fetchAddr | output | 64 | Word address, 16 bits per voice, voice c at bits 16c+15:16c |
| fetchAck | input | 4 | Acknowledge, one voice per cycle, data valid with it |
| fetchData | input | 16 | Fetched word |
| irq | output | 4 | One-cycle pulse on block reload |
| outRight | output | 16 | Signed sum of voices 0 and 2 |
| outLeft | output | 16 | Signed sum of voices 1 and 3 |

## Verification
The properties assume that the arbiter acknowledges only a voice that is requesting, grants at most one voice per cycle and presents valid data together with the grant. The bench arbiter is combinational and always grants the lowest-numbered requester in the same cycle, so every request is served within four cycles. All periods used are at least 124, which leaves ample time for a refetch before the next sample boundary. Modulation and the `dmaEn` edges are changed only on falling clock edges, and a voice is always idle before its configuration is changed.

// File: rtl/voice_pkg.sv
`timescale 1ns/1ps
package voice_pkg;

  // strobes from a voice's sequencer to its datapath
  typedef struct packed {
    logic start;    // load pointer and count, clear holding word
    logic take;     // accept the word on fetchData
    logic consume;  // sample boundary: use the next half-word or modulation word
    logic stop;     // return to silence
  } voiceStrobe_t;

  typedef enum logic [1:0] {
    SEL_PTR = 2'd0,
    SEL_LEN = 2'd1,
    SEL_PER = 2'd2,
    SEL_VOL = 2'd3
  } regSel_e;

endpackage

// File: rtl/voice_ctrl.sv
`timescale 1ns/1ps
module voice_ctrl (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   dmaEn,
  input  logic                   holdFull,
  input  logic                   perZero,
  input  logic                   fetchAck,
  output logic                   fetchReq,
  output voice_pkg::voiceStrobe_t strobe
);

  typedef enum logic {ST_IDLE, ST_RUN} state_e;
  state_e state, stateNxt;

  always_comb begin
    strobe   = '0;
    stateNxt = state;
    fetchReq = 1'b0;
    case (state)
      ST_IDLE: begin
        if (dmaEn) begin
          strobe.start = 1'b1;
          stateNxt     = ST_RUN;
        end
      end
      ST_RUN: begin
        fetchReq    = dmaEn && !holdFull;
        strobe.take = fetchReq && fetchAck;
        if (perZero) begin
          if (!dmaEn) begin
            strobe.stop = 1'b1;
            stateNxt    = ST_IDLE;
          end else if (holdFull) begin
            strobe.consume = 1'b1;
          end
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

endmodule

// File: rtl/voice_dpath.sv
`timescale 1ns/1ps
module voice_dpath #(
  parameter int ADDR_W  = 16,
  parameter int SMP_W   = 8,
  parameter int VOL_W   = 7,
  parameter int MAX_VOL = 64,
  parameter int MIN_PER = 124,
  localparam int WORD_W = 2 * SMP_W,
  localparam int PROD_W = SMP_W + VOL_W
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  voice_pkg::voiceStrobe_t  strobe,
  input  logic [WORD_W-1:0]        fetchData,
  input  logic                     regWr,
  input  logic [1:0]               regSel,
  input  logic [WORD_W-1:0]        regData,
  input  logic                     modVolMe,
  input  logic                     modPerMe,
  input  logic                     inVolWr,
  input  logic                     inPerWr,
  input  logic [WORD_W-1:0]        inModData,
  output logic [ADDR_W-1:0]        fetchAddr,
  output logic                     holdFull,
  output logic                     perZero,
  output logic                     irq,
  output logic signed [PROD_W-1:0] product,
  output logic                     outVolWr,
  output logic                     outPerWr,
  output logic [WORD_W-1:0]        outModData
);
  import voice_pkg::*;

  logic [ADDR_W-1:0]        startPtr, ptr;
  logic [WORD_W-1:0]        lenReg, lenCnt;
  logic [WORD_W-1:0]        perReg, perCnt;
  logic [VOL_W-1:0]         volReg;
  logic [WORD_W-1:0]        holdWord;
  logic                     byteSel;
  logic signed [SMP_W-1:0]  curSample;
  logic signed [PROD_W:0]   prodWide;
  logic                     modeAny;

  function automatic logic [VOL_W-1:0] clampVol(input logic [WORD_W-1:0] d);
    return (d > WORD_W'(MAX_VOL)) ? VOL_W'(MAX_VOL) : VOL_W'(d);
  endfunction

  function automatic logic [WORD_W-1:0] clampPer(input logic [WORD_W-1:0] d);
    return (d < WORD_W'(MIN_PER)) ? WORD_W'(MIN_PER) : d;
  endfunction

  assign modeAny = modVolMe | modPerMe;

  // software writes first, neighbour modulation overrides in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startPtr <= '0;
      lenReg   <= WORD_W'(1);
      perReg   <= WORD_W'(MIN_PER);
      volReg   <= '0;
    end else begin
      if (regWr) begin
        case (regSel)
          SEL_PTR: startPtr <= ADDR_W'(regData);
          SEL_LEN: lenReg   <= regData;
          SEL_PER: perReg   <= clampPer(regData);
          SEL_VOL: volReg   <= clampVol(regData);
          default: ;
        endcase
      end
      if (inVolWr) volReg <= clampVol(inModData);
      if (inPerWr) perReg <= clampPer(inModData);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ptr       <= '0;
      lenCnt    <= '0;
      holdWord  <= '0;
      holdFull  <= 1'b0;
      byteSel   <= 1'b0;
      curSample <= '0;
      perCnt    <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (strobe.start) begin
        ptr      <= startPtr;
        lenCnt   <= lenReg;
        holdFull <= 1'b0;
        byteSel  <= 1'b0;
        perCnt   <= '0;
      end else begin
        if (strobe.take) begin
          holdWord <= fetchData;
          holdFull <= 1'b1;
          if (lenCnt <= WORD_W'(1)) begin
            ptr    <= startPtr;
            lenCnt <= lenReg;
            irq    <= 1'b1;
          end else begin
            ptr    <= ptr + 1'b1;
            lenCnt <= lenCnt - 1'b1;
          end
        end
        if (strobe.consume) begin
          perCnt <= perReg - 1'b1;
          if (modeAny) begin
            holdFull <= 1'b0;
            byteSel  <= (modVolMe & modPerMe) ? ~byteSel : 1'b0;
          end else begin
            curSample <= byteSel ? holdWord[SMP_W-1:0] : holdWord[WORD_W-1:SMP_W];
            byteSel   <= ~byteSel;
            if (byteSel) holdFull <= 1'b0;
          end
        end else if (perCnt != '0) begin
          perCnt <= perCnt - 1'b1;
        end
        if (strobe.stop) begin
          curSample <= '0;
          holdFull  <= 1'b0;
        end
      end
    end
  end

  assign fetchAddr  = ptr;
  assign perZero    = (perCnt == '0);
  assign prodWide   = curSample * $signed({1'b0, volReg});
  assign product    = modeAny ? '0 : prodWide[PROD_W-1:0];
  assign outVolWr   = strobe.consume & modVolMe & (!modPerMe | !byteSel);
  assign outPerWr   = strobe.consume & modPerMe & (!modVolMe | byteSel);
  assign outModData = holdWord;

endmodule

// File: rtl/audio_voice_mixer.sv
`timescale 1ns/1ps
module audio_voice_mixer #(
  parameter int NUM_CH  = 4,
  parameter int ADDR_W  = 16,
  parameter int SMP_W   = 8,
  parameter int VOL_W   = 7,
  parameter int MAX_VOL = 64,
  parameter int MIN_PER = 124,
  localparam int CH_W   = $clog2(NUM_CH),
  localparam int WORD_W = 2 * SMP_W,
  localparam int PROD_W = SMP_W + VOL_W,
  localparam int MIX_W  = PROD_W + CH_W - 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       regWr,
  input  logic [CH_W-1:0]            regChan,
  input  logic [1:0]                 regSel,
  input  logic [WORD_W-1:0]          regData,
  input  logic [NUM_CH-1:0]          dmaEn,
  input  logic [NUM_CH-1:0]          modVol,
  input  logic [NUM_CH-1:0]          modPer,
  output logic [NUM_CH-1:0]          fetchReq,
  output logic [NUM_CH*ADDR_W-1:0]   fetchAddr,
  input  logic [NUM_CH-1:0]          fetchAck,
  input  logic [WORD_W-1:0]          fetchData,
  output logic [NUM_CH-1:0]          irq,
  output logic signed [MIX_W-1:0]    outRight,
  output logic signed [MIX_W-1:0]    outLeft
);

  logic                     volWrBus [NUM_CH];
  logic                     perWrBus [NUM_CH];
  logic [WORD_W-1:0]        modDataBus [NUM_CH];
  logic signed [PROD_W-1:0] prodBus [NUM_CH];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_voice
    localparam int SRC = (c + NUM_CH - 1) % NUM_CH;
    voice_pkg::voiceStrobe_t strobe;
    logic holdFull, perZero;

    voice_ctrl u_ctrl (
      .clk      (clk),
      .rstN     (rstN),
      .dmaEn    (dmaEn[c]),
      .holdFull (holdFull),
      .perZero  (perZero),
      .fetchAck (fetchAck[c]),
      .fetchReq (fetchReq[c]),
      .strobe   (strobe)
    );

    voice_dpath #(
      .ADDR_W (ADDR_W), .SMP_W (SMP_W), .VOL_W (VOL_W),
      .MAX_VOL(MAX_VOL), .MIN_PER(MIN_PER)
    ) u_dpath (
      .clk        (clk),
      .rstN       (rstN),
      .strobe     (strobe),
      .fetchData  (fetchData),
      .regWr      (regWr && (regChan == CH_W'(c))),
      .regSel     (regSel),
      .regData    (regData),
      .modVolMe   (modVol[c]),
      .modPerMe   (modPer[c]),
      .inVolWr    (volWrBus[SRC]),
      .inPerWr    (perWrBus[SRC]),
      .inModData  (modDataBus[SRC]),
      .fetchAddr  (fetchAddr[c*ADDR_W +: ADDR_W]),
      .holdFull   (holdFull),
      .perZero    (perZero),
      .irq        (irq[c]),
      .product    (prodBus[c]),
      .outVolWr   (volWrBus[c]),
      .outPerWr   (perWrBus[c]),
      .outModData (modDataBus[c])
    );
  end

  // even voices to the right side, odd voices to the left side
  always_comb begin
    outRight = '0;
    outLeft  = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (c % 2 == 0) outRight = outRight + MIX_W'(prodBus[c]);
      else            outLeft  = outLeft  + MIX_W'(prodBus[c]);
    end
  end

endmodule

// File: rtl/audio_voice_mixer_chk.sv
`timescale 1ns/1ps
module audio_voice_mixer_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic [NUM_CH-1:0]        dmaEn,
  input logic [NUM_CH-1:0]        fetchReq,
  input logic [NUM_CH-1:0]        fetchAck,
  input logic [NUM_CH-1:0]        irq,
  input logic [NUM_CH*ADDR_W-1:0] fetchAddr
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
      (fetchReq[c] && !fetchAck[c] && dmaEn[c]) |=> $stable(fetchAddr[c*ADDR_W +: ADDR_W]));

    assert_irq_after_take_R6: assert property (@(posedge clk) disable iff (!rstN)
      irq[c] |-> $past(fetchReq[c] && fetchAck[c]));

    assert_no_back_to_back_R11: assert property (@(posedge clk) disable iff (!rstN)
      (fetchReq[c] && fetchAck[c]) |=> !fetchReq[c]);

    assert_pending_kept_R11: assert property (@(posedge clk) disable iff (!rstN)
      (fetchReq[c] && !fetchAck[c]) |=> (fetchReq[c] || !dmaEn[c]));

    assert_req_needs_enable_R12: assert property (@(posedge clk) disable iff (!rstN)
      $fell(dmaEn[c]) |-> !fetchReq[c]);
  end

endmodule

bind audio_voice_mixer audio_voice_mixer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .dmaEn(dmaEn), .fetchReq(fetchReq),
  .fetchAck(fetchAck), .irq(irq), .fetchAddr(fetchAddr)
);

// File: tb/audio_voice_mixer_tb.sv
`timescale 1ns/1ps
module audio_voice_mixer_tb;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               regWr = 1'b0;
  logic [1:0]         regChan = '0;
  logic [1:0]         regSel = '0;
  logic [15:0]        regData = '0;
  logic [3:0]         dmaEn = '0;
  logic [3:0]         modVol = '0;
  logic [3:0]         modPer = '0;
  logic [3:0]         fetchReq;
  logic [63:0]        fetchAddr;
  logic [3:0]         fetchAck;
  logic [15:0]        fetchData;
  logic [3:0]         irq;
  logic signed [15:0] outRight, outLeft;

  int errors = 0;
  int checks = 0;
  int takeCnt0 = 0;
  int irqCnt0 = 0;
  logic [15:0] mem [64];

  always #2.5 clk = ~clk;

  audio_voice_mixer u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regChan(regChan), .regSel(regSel),
    .regData(regData), .dmaEn(dmaEn), .modVol(modVol), .modPer(modPer),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchAck(fetchAck),
    .fetchData(fetchData), .irq(irq), .outRight(outRight), .outLeft(outLeft)
  );

  // memory model with a fixed-priority arbiter answering in the same cycle
  always_comb begin
    logic found;
    found = 1'b0;
    fetchAck = '0;
    fetchData = '0;
    for (int c = 0; c < 4; c++) begin
      if (fetchReq[c] && !found) begin
        found = 1'b1;
        fetchAck[c] = 1'b1;
        fetchData = mem[fetchAddr[c*16 +: 6]];
      end
    end
  end

  always @(negedge clk) begin
    if (fetchAck[0]) takeCnt0++;
    if (irq[0]) irqCnt0++;
  end

  // stimulus/expectation rows: period, volume, start, length, samples checked
  localparam int VEC [4][5] = '{
    '{124,  64,  0, 3, 10},
    '{300,  32,  8, 1,  6},
    '{150,   0, 16, 2,  8},
    '{130, 100, 20, 4, 12}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeReg(input int ch, input int sel, input int data);
    @(negedge clk);
    regWr = 1'b1; regChan = 2'(ch); regSel = 2'(sel); regData = 16'(data);
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic setVoice(input int ch, input int st, input int len, input int per, input int vol);
    writeReg(ch, 0, st);
    writeReg(ch, 1, len);
    writeReg(ch, 2, per);
    writeReg(ch, 3, vol);
  endtask

  function automatic int sampleAt(input int st, input int len, input int k);
    logic [15:0] w;
    w = mem[st + (k / 2) % len];
    return (k % 2 == 0) ? int'($signed(w[15:8])) : int'($signed(w[7:0]));
  endfunction

  function automatic int effVol(input int v);
    return (v > 64) ? 64 : v;
  endfunction

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not complete (all requirements) actual=hung expected=done");
    finishRun();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = {8'(i * 37 + 5), 8'(i * 37 + 200)};
    mem[40] = 16'h1010; mem[41] = 16'h1010;
    mem[44] = 16'h1122;
    mem[48] = 16'd20;
    mem[52] = 16'd200;
    mem[56] = 16'd30;   mem[57] = 16'd300;

    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check("R1 outRight", int'(outRight), 0);
    check("R1 outLeft", int'(outLeft), 0);
    check("R1 fetchReq", int'(fetchReq), 0);
    check("R1 irq", int'(irq), 0);
    rstN = 1'b1;

    // table walk on voice 0: R2 ordering, R3 pacing, R5 scaling, R6 looping, R11 fetch count
    for (int r = 0; r < 4; r++) begin
      int per, vol, st, len, n;
      per = VEC[r][0]; vol = VEC[r][1]; st = VEC[r][2]; len = VEC[r][3]; n = VEC[r][4];
      setVoice(0, st, len, per, vol);
      takeCnt0 = 0;
      irqCnt0 = 0;
      @(negedge clk) dmaEn[0] = 1'b1;
      repeat (3 + per / 2) @(posedge clk);
      @(negedge clk);
      for (int k = 0; k < n; k++) begin
        if (k > 0) begin
          repeat (per) @(posedge clk);
          @(negedge clk);
        end
        check("R2 R3 R5 sample", int'(outRight), sampleAt(st, len, k) * effVol(vol));
      end
      repeat (2) @(posedge clk);
      @(negedge clk);
      #1;
      check("R11 words fetched", takeCnt0, 1 + n / 2);
      check("R6 reload irq count", irqCnt0, (1 + n / 2) / len);
      dmaEn[0] = 1'b0;
      repeat (per + 4) @(posedge clk);
    end

    // R3 and R4: period 10 acts as 124, sample boundary at edge 3+124
    setVoice(0, 0, 3, 10, 64);
    @(negedge clk) dmaEn[0] = 1'b1;
    repeat (103) @(posedge clk);
    @(negedge clk);
    check("R4 clamped period holds sample0", int'(outRight), sampleAt(0, 3, 0) * 64);
    repeat (23) @(posedge clk);
    @(negedge clk);
    check("R3 last cycle of sample0", int'(outRight), sampleAt(0, 3, 0) * 64);
    repeat (1) @(posedge clk);
    @(negedge clk);
    check("R3 R4 sample1 after 124 cycles", int'(outRight), sampleAt(0, 3, 1) * 64);
    dmaEn[0] = 1'b0;
    repeat (130) @(posedge clk);

    // R7: stereo routing with distinct volumes
    for (int c = 0; c < 4; c++) setVoice(c, 40, 1, 200, 1 << c);
    @(negedge clk) dmaEn = 4'hF;
    repeat (20) @(posedge clk);
    @(negedge clk);
    check("R7 right = voices 0+2", int'(outRight), 16 * (1 + 4));
    check("R7 left = voices 1+3", int'(outLeft), 16 * (2 + 8));
    dmaEn = 4'h0;
    repeat (210) @(posedge clk);

    // R8: voice 0 drives voice 1 volume
    setVoice(0, 48, 1, 1000, 64);
    setVoice(1, 40, 1, 1000, 64);
    @(negedge clk) begin modVol = 4'b0001; dmaEn = 4'b0011; end
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R8 target volume from word", int'(outLeft), 16 * 20);
    check("R8 modulator silent", int'(outRight), 0);
    dmaEn = 4'h0;
    repeat (1010) @(posedge clk);
    @(negedge clk) modVol = 4'h0;

    // R9: voice 0 drives voice 1 period (200 instead of 1000)
    setVoice(0, 52, 1, 2000, 64);
    setVoice(1, 44, 1, 1000, 1);
    @(negedge clk) begin modPer = 4'b0001; dmaEn = 4'b0011; end
    repeat (150) @(posedge clk);
    @(negedge clk);
    check("R9 first sample", int'(outLeft), 17);
    repeat (60) @(posedge clk);
    @(negedge clk);
    check("R9 second sample after modulated period", int'(outLeft), 34);
    check("R9 modulator silent", int'(outRight), 0);
    dmaEn = 4'h0;
    repeat (2010) @(posedge clk);
    @(negedge clk) modPer = 4'h0;

    // R10: both bits, words alternate volume then period
    setVoice(0, 56, 2, 130, 64);
    setVoice(1, 40, 1, 1000, 64);
    @(negedge clk) begin modVol = 4'b0001; modPer = 4'b0001; dmaEn = 4'b0011; end
    repeat (10) @(posedge clk);
    @(negedge clk);
    check("R10 first word to volume", int'(outLeft), 16 * 30);
    repeat (130) @(posedge clk);
    @(negedge clk);
    check("R10 second word not to volume", int'(outLeft), 16 * 30);
    check("R10 modulator silent", int'(outRight), 0);
    dmaEn = 4'h0;
    repeat (1010) @(posedge clk);
    @(negedge clk) begin modVol = 4'h0; modPer = 4'h0; end

    // R12: disable right after the low byte is used
    setVoice(0, 0, 3, 200, 64);
    takeCnt0 = 0;
    @(negedge clk) dmaEn[0] = 1'b1;
    repeat (203) @(posedge clk);
    @(negedge clk);
    dmaEn[0] = 1'b0;
    #1;
    check("R12 request dropped at once", int'(fetchReq[0]), 0);
    repeat (97) @(posedge clk);
    @(negedge clk);
    check("R12 current sample kept", int'(outRight), sampleAt(0, 3, 1) * 64);
    repeat (102) @(posedge clk);
    @(negedge clk);
    check("R12 held to end of period", int'(outRight), sampleAt(0, 3, 1) * 64);
    repeat (1) @(posedge clk);
    @(negedge clk);
    check("R12 silent after stop", int'(outRight), 0);
    #1;
    check("R12 no word taken after disable", takeCnt0, 1);

    finishRun();
  end

endmodule